// File: doc/BRIEF.md
# RTC Seconds Counter with Staged Time Load and Alarm

This core is the timekeeping heart of a real-time clock. It holds an unsigned seconds count that moves forward once for each one-second strobe from an external tick generator. It also raises two interrupt lines, one for each elapsed second and one for an alarm match. Everything is reached through a plain 32-bit register bus that uses byte addresses on word boundaries. Register writes take effect at the clock edge on which the write strobe is high. Reads are combinational from the address.

Setting the time is a staged operation. Software writes the new value into a staging register, and that value becomes the live count only at the next second strobe. Until that strobe arrives, a readback register returns the staged value. The seconds status bit is set on every strobe, including the strobe that loads the staged value. Software can therefore clear that bit right after writing a new time and then poll it to learn whether the load has happened.

Each interrupt source has three controls:
- a status bit that software clears by writing a one to it;
- a mask bit that software can read;
- a pair of write-one strobes, one to enable the source and one to disable it.

Top module: `rtc_core`

## Requirements
- R1: After reset the seconds count, the staged time, the alarm value and the status bits are all zero. The mask register reads 0x3, meaning both sources are masked, and both interrupt lines are low.
- R2: A write to offset 0x00 stores the write data as the staged time, and offset 0x04 returns it from the next cycle on. The count at offset 0x10 keeps its value until a strobe arrives. If the write falls on the same cycle as a strobe, that strobe works on the earlier state, and the new value waits for the following strobe.
- R3: On a strobe, if a staged time is waiting, the count takes the staged value. The waiting flag is then cleared.
- R4: On a strobe with no staged time waiting, the count goes up by one, modulo 2^32, so 0xFFFFFFFF becomes 0. Without a strobe the count holds its value.
- R5: Status bit 0 (the seconds event) at offset 0x20 is set on every strobe, including a strobe that loads a staged time.
- R6: Status bit 1 (the alarm event) is set on a strobe when the count it produces equals the alarm value held at offset 0x18, which is readable and writable. Writing the alarm register alone never sets the bit, even when the value matches the current count.
- R7: Writing a 1 to a bit at offset 0x20 clears that status bit, and writing a 0 leaves it as it is. If an event sets a bit in the same cycle as a clear, the set wins.
- R8: Writing a 1 to bit i at offset 0x28 unmasks source i. Writing a 1 to bit i at offset 0x2C masks it. Offset 0x24 reads the mask bits, with 1 meaning masked. Bit 0 is the seconds source and bit 1 is the alarm source.
- R9: `irq_sec` is status bit 0 AND NOT mask bit 0. `irq_alarm` is status bit 1 AND NOT mask bit 1.
- R10: Offset 0x14 returns the live `tick_count` input, zero-extended.
- R11: Reads of an unmapped offset return 0, and reads of the write-only offsets 0x00, 0x28 and 0x2C return 0. Any access whose address bits [1:0] are not zero is ignored and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_strobe | input | 1 | One-cycle pulse, once per second |
| tick_count | input | TICK_W (16) | Live sub-second tick counter value |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_sec | output | 1 | Seconds interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
Every state change lands at the first rising edge after its stimulus. This covers register writes, count loads and increments, and the setting of status and mask bits. The interrupt lines and the read data follow that edge combinationally, so each result is due exactly one edge after its inputs were applied. The bench applies stimulus just after a falling edge, updates its behavioural model at the rising edge, and compares the read data and both interrupt lines at the next falling edge. The directed scenarios use the same timing and check the same-cycle collisions: a time write during a strobe, and a clear during a set.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;

  // word indices (byte offset >> 2)
  localparam int WIDX_STAGE_WR = 0;   // 0x00
  localparam int WIDX_STAGE_RD = 1;   // 0x04
  localparam int WIDX_NOW      = 4;   // 0x10
  localparam int WIDX_TICK     = 5;   // 0x14
  localparam int WIDX_ALARM    = 6;   // 0x18
  localparam int WIDX_STATUS   = 8;   // 0x20
  localparam int WIDX_MASK     = 9;   // 0x24
  localparam int WIDX_UNMASK   = 10;  // 0x28
  localparam int WIDX_DOMASK   = 11;  // 0x2C

  // interrupt source bit positions, shared by all interrupt registers
  localparam int SRC_SEC   = 0;
  localparam int SRC_ALARM = 1;
  localparam int SRC_COUNT = 2;

  typedef struct packed {
    logic stage;
    logic alarm;
    logic clr;
    logic unmask;
    logic domask;
  } wr_hits_t;

endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
  import rtc_core_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int TICK_W = 16,
  parameter int NSRC   = SRC_COUNT
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  staged_val,
  input  logic [CNT_W-1:0]  now_val,
  input  logic [TICK_W-1:0] tick_val,
  input  logic [CNT_W-1:0]  alarm_val,
  input  logic [NSRC-1:0]   status_val,
  input  logic [NSRC-1:0]   mask_val,
  output wr_hits_t          hits,
  output logic [DATA_W-1:0] rdata
);

  logic aligned;
  int   widx;

  always_comb begin
    aligned = (bus_addr[1:0] == 2'b00);
    widx    = int'(bus_addr[ADDR_W-1:2]);
  end

  always_comb begin
    hits = '0;
    if (bus_wr && aligned) begin
      case (widx)
        WIDX_STAGE_WR: hits.stage  = 1'b1;
        WIDX_ALARM:    hits.alarm  = 1'b1;
        WIDX_STATUS:   hits.clr    = 1'b1;
        WIDX_UNMASK:   hits.unmask = 1'b1;
        WIDX_DOMASK:   hits.domask = 1'b1;
        default:       hits        = '0;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      case (widx)
        WIDX_STAGE_RD: rdata = DATA_W'(staged_val);
        WIDX_NOW:      rdata = DATA_W'(now_val);
        WIDX_TICK:     rdata = DATA_W'(tick_val);
        WIDX_ALARM:    rdata = DATA_W'(alarm_val);
        WIDX_STATUS:   rdata = DATA_W'(status_val);
        WIDX_MASK:     rdata = DATA_W'(mask_val);
        default:       rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_strobe,
  input  logic             stage_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] now_q,
  output logic [CNT_W-1:0] staged_q,
  output logic             pending_q,
  output logic [CNT_W-1:0] next_now
);

  // value the count takes at the coming strobe
  function automatic logic [CNT_W-1:0] advance(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] stg,
    input logic             pend
  );
    return pend ? stg : cur + 1'b1;
  endfunction

  always_comb next_now = advance(now_q, staged_q, pending_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q     <= '0;
      staged_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      if (sec_strobe) now_q <= next_now;
      if (stage_wr)   staged_q <= wdata;
      pending_q <= stage_wr | (pending_q & ~sec_strobe);
    end
  end

  assert_staged_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_strobe && pending_q) |=> (now_q == $past(staged_q)));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_strobe && !pending_q) |=> (now_q == $past(now_q) + 1'b1));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_strobe |=> $stable(now_q));

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alarm_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             sec_strobe,
  input  logic [CNT_W-1:0] next_now,
  output logic [CNT_W-1:0] alarm_q,
  output logic             alarm_hit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        alarm_q <= '0;
    else if (alarm_wr) alarm_q <= wdata;
  end

  // match is judged on the value the count is about to take
  always_comb alarm_hit = sec_strobe && (next_now == alarm_q);

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            clr_wr,
  input  logic            unmask_wr,
  input  logic            domask_wr,
  input  logic [NSRC-1:0] wbits,
  output logic [NSRC-1:0] status_q,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (evt[i])                    status_q[i] <= 1'b1;
        else if (clr_wr && wbits[i])   status_q[i] <= 1'b0;
        if (domask_wr && wbits[i])     mask_q[i] <= 1'b1;
        else if (unmask_wr && wbits[i]) mask_q[i] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign irq[g] = status_q[g] & ~mask_q[g];

    assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> status_q[g]);

    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && wbits[g] && !evt[g]) |=> !status_q[g]);

    assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (domask_wr && wbits[g]) |=> mask_q[g]);

    assert_mask_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (unmask_wr && wbits[g] && !domask_wr) |=> !mask_q[g]);
  end

endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_core_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_strobe,
  input  logic [TICK_W-1:0] tick_count,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_sec,
  output logic              irq_alarm
);

  localparam int DATA_W = 32;

  wr_hits_t             hits;
  logic [CNT_W-1:0]     now_q, staged_q, next_now, alarm_q;
  logic                 pending_q;
  logic                 alarm_hit;
  logic [SRC_COUNT-1:0] evt, status_q, mask_q, irq_vec;

  rtc_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .TICK_W(TICK_W), .NSRC(SRC_COUNT)
  ) u_decode (
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .staged_val (staged_q),
    .now_val    (now_q),
    .tick_val   (tick_count),
    .alarm_val  (alarm_q),
    .status_val (status_q),
    .mask_val   (mask_q),
    .hits       (hits),
    .rdata      (bus_rdata)
  );

  rtc_seconds #(.CNT_W(CNT_W)) u_seconds (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_strobe (sec_strobe),
    .stage_wr   (hits.stage),
    .wdata      (bus_wdata[CNT_W-1:0]),
    .now_q      (now_q),
    .staged_q   (staged_q),
    .pending_q  (pending_q),
    .next_now   (next_now)
  );

  rtc_alarm_cmp #(.CNT_W(CNT_W)) u_alarm (
    .clk        (clk),
    .rst_n      (rst_n),
    .alarm_wr   (hits.alarm),
    .wdata      (bus_wdata[CNT_W-1:0]),
    .sec_strobe (sec_strobe),
    .next_now   (next_now),
    .alarm_q    (alarm_q),
    .alarm_hit  (alarm_hit)
  );

  always_comb begin
    evt            = '0;
    evt[SRC_SEC]   = sec_strobe;
    evt[SRC_ALARM] = alarm_hit;
  end

  rtc_irq_ctrl #(.NSRC(SRC_COUNT)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .clr_wr    (hits.clr),
    .unmask_wr (hits.unmask),
    .domask_wr (hits.domask),
    .wbits     (bus_wdata[SRC_COUNT-1:0]),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .irq       (irq_vec)
  );

  assign irq_sec   = irq_vec[SRC_SEC];
  assign irq_alarm = irq_vec[SRC_ALARM];

  assert_alarm_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> status_q[SRC_ALARM]);

  assert_alarm_only_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_strobe && !$past(status_q[SRC_ALARM])) |=> !status_q[SRC_ALARM] || $past(status_q[SRC_ALARM]) || $past(alarm_hit));

  assert_stage_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hits.stage |=> (pending_q && staged_q == $past(bus_wdata[CNT_W-1:0])));

endmodule

// File: tb/rtc_core_tb.sv
module rtc_core_tb;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_strobe = 1'b0;
  logic [15:0] tick_count = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_sec, irq_alarm;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_core u_dut (
    .clk(clk), .rst_n(rst_n), .sec_strobe(sec_strobe), .tick_count(tick_count),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_sec(irq_sec), .irq_alarm(irq_alarm)
  );

  // behavioural reference model
  logic [31:0] m_now = 0, m_stg = 0, m_alarm = 0, m_next;
  logic        m_pend = 0;
  logic [1:0]  m_stat = 0, m_mask = 2'b11, m_set, m_clr, m_en, m_dis;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_now = 0; m_stg = 0; m_alarm = 0; m_pend = 0; m_stat = 0; m_mask = 2'b11;
    end else begin
      m_set = 0; m_clr = 0; m_en = 0; m_dis = 0;
      m_next = m_now;
      if (sec_strobe) begin
        m_next = m_pend ? m_stg : m_now + 1;
        m_set[0] = 1'b1;
        if (m_next == m_alarm) m_set[1] = 1'b1;
      end
      m_pend = m_pend && !sec_strobe;
      if (bus_wr && bus_addr[1:0] == 2'b00) begin
        case (bus_addr)
          8'h00: begin m_stg = bus_wdata; m_pend = 1'b1; end
          8'h18: m_alarm = bus_wdata;
          8'h20: m_clr = bus_wdata[1:0];
          8'h28: m_en  = bus_wdata[1:0];
          8'h2C: m_dis = bus_wdata[1:0];
          default: ;
        endcase
      end
      m_now  = m_next;
      m_stat = (m_stat & ~m_clr) | m_set;
      m_mask = (m_mask & ~m_en) | m_dis;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a[1:0] != 2'b00) return 0;
    case (a)
      8'h04: return m_stg;
      8'h10: return m_now;
      8'h14: return {16'h0, tick_count};
      8'h18: return m_alarm;
      8'h20: return {30'h0, m_stat};
      8'h24: return {30'h0, m_mask};
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h04: return "R2";
      8'h10: return "R3_R4";
      8'h14: return "R10";
      8'h18: return "R6";
      8'h20: return "R5_R7";
      8'h24: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock: inputs applied after a falling edge, results compared at the next one
  task automatic cyc(input logic [7:0] a, input logic w, input logic [31:0] d, input logic s);
    bus_addr = a; bus_wr = w; bus_wdata = d; sec_strobe = s;
    @(posedge clk);
    @(negedge clk);
    check(tag_of(a), "model rdata", bus_rdata, m_read(a));
    check("R9", "model irq_sec", {31'h0, irq_sec}, {31'h0, m_stat[0] & ~m_mask[0]});
    check("R9", "model irq_alarm", {31'h0, irq_alarm}, {31'h0, m_stat[1] & ~m_mask[1]});
    bus_wr = 1'b0; sec_strobe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    cyc(a, 1'b0, 0, 1'b0);
    check(tag, "read", bus_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(a, 1'b1, d, 1'b0);
  endtask

  task automatic strobe(input logic [7:0] a);
    cyc(a, 1'b0, 0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "irq lines in reset", {30'h0, irq_alarm, irq_sec}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h10, 0, "R1");
    rd(8'h20, 0, "R1");
    rd(8'h24, 3, "R1");
    rd(8'h18, 0, "R1");
    check("R1", "irq after reset", {30'h0, irq_alarm, irq_sec}, 0);

    wr(8'h00, 100);
    rd(8'h04, 100, "R2");
    rd(8'h10, 0, "R2");
    strobe(8'h10);
    check("R3", "staged load", bus_rdata, 100);
    rd(8'h20, 1, "R5");
    strobe(8'h10);
    check("R4", "increment", bus_rdata, 101);

    wr(8'h20, 0);
    rd(8'h20, 1, "R7");
    wr(8'h20, 1);
    rd(8'h20, 0, "R7");

    wr(8'h28, 1);
    rd(8'h24, 2, "R8");
    strobe(8'h10);
    check("R9", "irq_sec unmasked", {31'h0, irq_sec}, 1);
    wr(8'h2C, 1);
    rd(8'h24, 3, "R8");
    check("R9", "irq_sec masked", {31'h0, irq_sec}, 0);

    wr(8'h18, 104);
    rd(8'h18, 104, "R6");
    wr(8'h20, 3);
    strobe(8'h20);
    check("R6", "no match at 103", bus_rdata, 1);
    wr(8'h20, 3);
    strobe(8'h20);
    check("R6", "match at 104", bus_rdata, 3);
    wr(8'h28, 2);
    check("R9", "irq_alarm unmasked", {31'h0, irq_alarm}, 1);
    wr(8'h20, 3);
    wr(8'h18, 104);
    rd(8'h20, 0, "R6");

    cyc(8'h20, 1'b1, 1, 1'b1);
    check("R7", "set beats clear", {31'h0, bus_rdata[0]}, 1);

    wr(8'h00, 32'hFFFF_FFFF);
    strobe(8'h10);
    check("R3", "load max", bus_rdata, 32'hFFFF_FFFF);
    strobe(8'h10);
    check("R4", "wrap", bus_rdata, 0);

    cyc(8'h00, 1'b1, 500, 1'b1);
    rd(8'h10, 1, "R2");
    rd(8'h04, 500, "R2");
    strobe(8'h10);
    check("R3", "late staged load", bus_rdata, 500);

    tick_count = 16'hABCD;
    rd(8'h14, 32'h0000_ABCD, "R10");
    tick_count = 16'h1234;
    rd(8'h14, 32'h0000_1234, "R10");

    rd(8'h30, 0, "R11");
    rd(8'h12, 0, "R11");
    rd(8'h28, 0, "R11");
    wr(8'h02, 7);
    rd(8'h04, 500, "R11");

    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      case ($urandom % 10)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h10; 3: a = 8'h14; 4: a = 8'h18;
        5: a = 8'h20; 6: a = 8'h24; 7: a = 8'h28; 8: a = 8'h2C; default: a = 8'h01;
      endcase
      d = (a == 8'h18) ? m_now + ($urandom % 4) : $urandom;
      tick_count = 16'($urandom);
      cyc(a, ($urandom % 3) == 0, d, ($urandom % 4) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1-all: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule